// File: doc/BRIEF.md
# Display Command and Parameter Decoder

This block sits behind the serial receiver of a small graphic display controller. Each received byte arrives with a one-bit select level. When the level is high the byte is pixel data and is handed straight to the framebuffer writer. When it is low the byte belongs to a command. The first byte of a command is its opcode. Each opcode has a fixed number of parameter bytes that follow it. A command takes effect only once its final parameter byte has been received.

Commands that change state drive registered outputs. These are the column and row address windows, a 6-bit-free remap byte, the contrast level, a display-on flag and a four-way display-mode field. Analog tuning commands are parsed so that their parameters are skipped, but they have no effect. An opcode outside the supported set raises a one-cycle error strobe.

All outputs are registered. Every strobe and register update appears on the clock edge after the byte that caused it.

Top module: `oled_cmd_decoder`

## Requirements
- R1: After synchronous reset the outputs hold these values: column window 0..COLS-1, row window 0..ROWS-1, remap 0x00, contrast CONTRAST_RST (default 0x7F), display off, display mode 0 (normal). All strobes are low.
- R2: A valid byte with `dc_data` high pulses `data_stb` for one cycle on the next cycle, with `data_byte` equal to that byte. It never changes any command register.
- R3: Opcode 0x15 is followed by two parameters, start and then end. One cycle after the second parameter, `col_load` pulses for one cycle, with `col_start` = start mod COLS and `col_end` = end mod COLS.
- R4: Opcode 0x75 is followed by two parameters, start and then end. One cycle after the second parameter, `row_load` pulses for one cycle, with `row_start` = start mod ROWS and `row_end` = end mod ROWS.
- R5: Opcode 0x81 plus one parameter loads `contrast` with that parameter. Contrast changes only after a command-mode byte.
- R6: Opcode 0xA0 plus one parameter loads `remap` with that parameter.
- R7: Opcodes 0xA4, 0xA5, 0xA6 and 0xA7 set `disp_mode` to 0 (normal), 1 (all on), 2 (all off) and 3 (inverse). Opcode 0xAE clears `disp_on` and 0xAF sets it. None of these opcodes takes a parameter.
- R8: Opcodes 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF each consume exactly one parameter byte and have no effect. The byte after that parameter is decoded as an opcode.
- R9: Opcode 0xB8 consumes exactly eight parameter bytes and has no effect. The byte after them is decoded as an opcode.
- R10: Opcodes 0x84, 0x85, 0x86, 0xE3 and 0xFF take no parameters and have no effect. The next byte is decoded as an opcode.
- R11: Any other opcode pulses `cmd_err` for one cycle on the next cycle and consumes no parameters. The next byte is decoded as an opcode.
- R12: While `dc_data` is high, any partially received command is discarded. The next command-mode byte is decoded as a new opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | A byte is present on `byte_in` this cycle |
| dc_data | input | 1 | 1 = data byte, 0 = command byte |
| byte_in | input | 8 | Received byte |
| col_load | output | 1 | Column window load strobe |
| col_start | output | $clog2(COLS) | Column window start |
| col_end | output | $clog2(COLS) | Column window end |
| row_load | output | 1 | Row window load strobe |
| row_start | output | $clog2(ROWS) | Row window start |
| row_end | output | $clog2(ROWS) | Row window end |
| remap | output | 8 | Remap configuration byte |
| contrast | output | 8 | Contrast level |
| disp_on | output | 1 | Display enabled |
| disp_mode | output | 2 | 0 normal, 1 all on, 2 all off, 3 inverse |
| data_stb | output | 1 | Pixel data byte strobe |
| data_byte | output | 8 | Pixel data byte |
| cmd_err | output | 1 | Unknown opcode strobe |

## Verification
The bench builds the decoder with its defaults: COLS = 64, ROWS = 80 and an eight-entry parameter buffer. A row count of 80 is not a power of two, so the row checks exercise a true modulo rather than a bit mask. Parameter bytes of 0x55 and 0xFF wrap to distinct row values. The eight-entry buffer lets the 0xB8 command fill it completely. The bench then checks that the following byte is decoded as an opcode. Parameter bytes in the stimulus are chosen to equal valid opcodes. As a result, a wrong parameter count shows up as a visible contrast or window change, or as an unexpected error strobe.

// File: rtl/oled_cmd_pkg.sv
package oled_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_ALL_ON  = 2'd1,
    MODE_ALL_OFF = 2'd2,
    MODE_INVERSE = 2'd3
  } disp_mode_e;

  localparam logic [7:0] OP_COL_WIN  = 8'h15;
  localparam logic [7:0] OP_ROW_WIN  = 8'h75;
  localparam logic [7:0] OP_CONTRAST = 8'h81;
  localparam logic [7:0] OP_REMAP    = 8'hA0;
  localparam logic [7:0] OP_GREY     = 8'hB8;
  localparam logic [7:0] OP_DISP_OFF = 8'hAE;
  localparam logic [7:0] OP_DISP_ON  = 8'hAF;

  // Number of parameter bytes carried by the grey-level table command
  localparam int GREY_LEN = 8;

endpackage

// File: rtl/oled_op_table.sv
module oled_op_table
  import oled_cmd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [7:0]       opcode,
  output logic             known,
  output logic [CNT_W-1:0] nparam
);

  int n;

  always_comb begin
    known = 1'b1;
    n     = 0;
    case (opcode)
      OP_COL_WIN, OP_ROW_WIN: n = 2;
      OP_CONTRAST, OP_REMAP,
      8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF: n = 1;
      OP_GREY: n = GREY_LEN;
      8'h84, 8'h85, 8'h86,
      8'hA4, 8'hA5, 8'hA6, 8'hA7,
      OP_DISP_OFF, OP_DISP_ON,
      8'hE3, 8'hFF: n = 0;
      default: known = 1'b0;
    endcase
    nparam = CNT_W'(n);
  end

endmodule

// File: rtl/oled_cmd_collect.sv
module oled_cmd_collect #(
  parameter int MAX_PARAMS = 8,
  parameter int CNT_W      = $clog2(MAX_PARAMS + 1),
  parameter int IDX_W      = $clog2(MAX_PARAMS)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_valid,
  input  logic       dc_data,
  input  logic [7:0] byte_in,
  output logic       fire,
  output logic       fire_known,
  output logic [7:0] fire_op,
  output logic [7:0] fire_p0,
  output logic [7:0] fire_p1
);

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       op_q;
  logic [7:0]       par_q [MAX_PARAMS];
  logic             cmd_byte;
  logic             first;
  logic             last;
  logic             lk_known;
  logic [CNT_W-1:0] lk_n;
  logic [IDX_W-1:0] wr_idx;

  assign cmd_byte = byte_valid & ~dc_data;
  assign first    = (cnt_q == '0);
  assign fire_op  = first ? byte_in : op_q;
  assign wr_idx   = IDX_W'(cnt_q - CNT_W'(1));

  oled_op_table #(.CNT_W(CNT_W)) u_table (
    .opcode (fire_op),
    .known  (lk_known),
    .nparam (lk_n)
  );

  // On the opcode byte, done when no parameters follow; otherwise done
  // when the byte count (opcode included, minus one) reaches the need.
  assign last       = first ? (lk_n == '0) : (cnt_q == lk_n);
  assign fire       = cmd_byte & last;
  assign fire_known = lk_known;
  assign fire_p0    = (cnt_q == CNT_W'(1)) ? byte_in : par_q[0];
  assign fire_p1    = (cnt_q == CNT_W'(2)) ? byte_in : par_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      op_q  <= '0;
    end else if (dc_data) begin
      cnt_q <= '0;
    end else if (cmd_byte) begin
      if (first) op_q <= byte_in;
      if (last) cnt_q <= '0;
      else      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // Parameter store without reset so it maps onto plain storage
  always_ff @(posedge clk) begin
    if (cmd_byte && !first && (32'(wr_idx) < MAX_PARAMS))
      par_q[wr_idx] <= byte_in;
  end

endmodule

// File: rtl/oled_cmd_exec.sv
module oled_cmd_exec
  import oled_cmd_pkg::*;
#(
  parameter int         COLS         = 64,
  parameter int         ROWS         = 80,
  parameter logic [7:0] CONTRAST_RST = 8'h7F,
  parameter int         COL_W        = $clog2(COLS),
  parameter int         ROW_W        = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data_take,
  input  logic [7:0]       byte_in,
  input  logic             fire,
  input  logic             fire_known,
  input  logic [7:0]       fire_op,
  input  logic [7:0]       fire_p0,
  input  logic [7:0]       fire_p1,
  output logic             col_load,
  output logic [COL_W-1:0] col_start,
  output logic [COL_W-1:0] col_end,
  output logic             row_load,
  output logic [ROW_W-1:0] row_start,
  output logic [ROW_W-1:0] row_end,
  output logic [7:0]       remap,
  output logic [7:0]       contrast,
  output logic             disp_on,
  output disp_mode_e       disp_mode,
  output logic             data_stb,
  output logic [7:0]       data_byte,
  output logic             cmd_err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_load  <= 1'b0;
      col_start <= '0;
      col_end   <= COL_W'(COLS - 1);
      row_load  <= 1'b0;
      row_start <= '0;
      row_end   <= ROW_W'(ROWS - 1);
      remap     <= 8'h00;
      contrast  <= CONTRAST_RST;
      disp_on   <= 1'b0;
      disp_mode <= MODE_NORMAL;
      data_stb  <= 1'b0;
      data_byte <= 8'h00;
      cmd_err   <= 1'b0;
    end else begin
      col_load <= 1'b0;
      row_load <= 1'b0;
      data_stb <= 1'b0;
      cmd_err  <= 1'b0;
      if (data_take) begin
        data_stb  <= 1'b1;
        data_byte <= byte_in;
      end
      if (fire) begin
        if (!fire_known) begin
          cmd_err <= 1'b1;
        end else begin
          case (fire_op)
            OP_COL_WIN: begin
              col_load  <= 1'b1;
              col_start <= COL_W'(32'(fire_p0) % COLS);
              col_end   <= COL_W'(32'(fire_p1) % COLS);
            end
            OP_ROW_WIN: begin
              row_load  <= 1'b1;
              row_start <= ROW_W'(32'(fire_p0) % ROWS);
              row_end   <= ROW_W'(32'(fire_p1) % ROWS);
            end
            OP_CONTRAST: contrast <= fire_p0;
            OP_REMAP:    remap    <= fire_p0;
            8'hA4, 8'hA5, 8'hA6, 8'hA7: disp_mode <= disp_mode_e'(fire_op[1:0]);
            OP_DISP_OFF, OP_DISP_ON:    disp_on   <= fire_op[0];
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/oled_cmd_decoder.sv
module oled_cmd_decoder
  import oled_cmd_pkg::*;
#(
  parameter int         COLS         = 64,
  parameter int         ROWS         = 80,
  parameter int         MAX_PARAMS   = 8,
  parameter logic [7:0] CONTRAST_RST = 8'h7F,
  parameter int         COL_W        = $clog2(COLS),
  parameter int         ROW_W        = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_valid,
  input  logic             dc_data,
  input  logic [7:0]       byte_in,
  output logic             col_load,
  output logic [COL_W-1:0] col_start,
  output logic [COL_W-1:0] col_end,
  output logic             row_load,
  output logic [ROW_W-1:0] row_start,
  output logic [ROW_W-1:0] row_end,
  output logic [7:0]       remap,
  output logic [7:0]       contrast,
  output logic             disp_on,
  output logic [1:0]       disp_mode,
  output logic             data_stb,
  output logic [7:0]       data_byte,
  output logic             cmd_err
);

  localparam int CNT_W = $clog2(MAX_PARAMS + 1);

  logic       fire;
  logic       fire_known;
  logic [7:0] fire_op;
  logic [7:0] fire_p0;
  logic [7:0] fire_p1;
  disp_mode_e mode_q;

  oled_cmd_collect #(.MAX_PARAMS(MAX_PARAMS), .CNT_W(CNT_W)) u_collect (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (byte_valid),
    .dc_data    (dc_data),
    .byte_in    (byte_in),
    .fire       (fire),
    .fire_known (fire_known),
    .fire_op    (fire_op),
    .fire_p0    (fire_p0),
    .fire_p1    (fire_p1)
  );

  oled_cmd_exec #(
    .COLS(COLS), .ROWS(ROWS), .CONTRAST_RST(CONTRAST_RST),
    .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_exec (
    .clk        (clk),
    .rst        (rst),
    .data_take  (byte_valid & dc_data),
    .byte_in    (byte_in),
    .fire       (fire),
    .fire_known (fire_known),
    .fire_op    (fire_op),
    .fire_p0    (fire_p0),
    .fire_p1    (fire_p1),
    .col_load   (col_load),
    .col_start  (col_start),
    .col_end    (col_end),
    .row_load   (row_load),
    .row_start  (row_start),
    .row_end    (row_end),
    .remap      (remap),
    .contrast   (contrast),
    .disp_on    (disp_on),
    .disp_mode  (mode_q),
    .data_stb   (data_stb),
    .data_byte  (data_byte),
    .cmd_err    (cmd_err)
  );

  assign disp_mode = mode_q;

endmodule

// File: rtl/oled_cmd_decoder_chk.sv
module oled_cmd_decoder_chk #(
  parameter int COLS  = 64,
  parameter int ROWS  = 80,
  parameter int COL_W = $clog2(COLS),
  parameter int ROW_W = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst,
  input logic             byte_valid,
  input logic             dc_data,
  input logic [7:0]       byte_in,
  input logic             col_load,
  input logic [COL_W-1:0] col_start,
  input logic [COL_W-1:0] col_end,
  input logic             row_load,
  input logic [ROW_W-1:0] row_start,
  input logic [ROW_W-1:0] row_end,
  input logic [7:0]       remap,
  input logic [7:0]       contrast,
  input logic             disp_on,
  input logic [1:0]       disp_mode,
  input logic             data_stb,
  input logic [7:0]       data_byte,
  input logic             cmd_err
);

  p_data_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && dc_data) |=> (data_stb && data_byte == $past(byte_in)));

  p_no_stray_data_r2: assert property (@(posedge clk) disable iff (rst)
    !(byte_valid && dc_data) |=> !data_stb);

  p_col_range_r3: assert property (@(posedge clk) disable iff (rst)
    col_load |-> (32'(col_start) < COLS && 32'(col_end) < COLS));

  p_row_range_r4: assert property (@(posedge clk) disable iff (rst)
    row_load |-> (32'(row_start) < ROWS && 32'(row_end) < ROWS));

  p_contrast_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(byte_valid && !dc_data) |=> $stable(contrast));

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(byte_valid && !dc_data) |=> ($stable(disp_mode) && $stable(disp_on) && $stable(remap)));

  p_err_source_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(byte_valid && !dc_data));

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({col_load, row_load, data_stb, cmd_err}));

endmodule

bind oled_cmd_decoder oled_cmd_decoder_chk #(
  .COLS(COLS), .ROWS(ROWS), .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (.*);

// File: tb/oled_cmd_decoder_test.sv
`timescale 1ns/1ps
module oled_cmd_decoder_test;

  localparam int COLS = 64;
  localparam int ROWS = 80;
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);

  localparam int K_DATA = 0;
  localparam int K_COL  = 1;
  localparam int K_ROW  = 2;
  localparam int K_ERR  = 3;

  typedef struct {
    int    kind;
    int    a;
    int    b;
    string req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             byte_valid = 1'b0;
  logic             dc_data = 1'b0;
  logic [7:0]       byte_in = 8'h00;
  logic             col_load;
  logic [COL_W-1:0] col_start;
  logic [COL_W-1:0] col_end;
  logic             row_load;
  logic [ROW_W-1:0] row_start;
  logic [ROW_W-1:0] row_end;
  logic [7:0]       remap;
  logic [7:0]       contrast;
  logic             disp_on;
  logic [1:0]       disp_mode;
  logic             data_stb;
  logic [7:0]       data_byte;
  logic             cmd_err;

  int   checks = 0;
  int   failures = 0;
  bit   finished = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  oled_cmd_decoder #(.COLS(COLS), .ROWS(ROWS)) uut (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .dc_data(dc_data),
    .byte_in(byte_in), .col_load(col_load), .col_start(col_start),
    .col_end(col_end), .row_load(row_load), .row_start(row_start),
    .row_end(row_end), .remap(remap), .contrast(contrast),
    .disp_on(disp_on), .disp_mode(disp_mode), .data_stb(data_stb),
    .data_byte(data_byte), .cmd_err(cmd_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int a, input int b, input string req);
    exp_t e;
    e.kind = kind; e.a = a; e.b = b; e.req = req;
    q.push_back(e);
  endtask

  task automatic observe(input int kind, input int a, input int b);
    exp_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R2/R3/R4/R11 unexpected strobe", kind, -1);
    end else begin
      e = q.pop_front();
      chk(e.kind == kind, e.req, kind, e.kind);
      if (e.kind == kind) begin
        chk(e.a == a, e.req, a, e.a);
        chk(e.b == b, e.req, b, e.b);
      end
    end
  endtask

  // Monitor: pops one expected item per observed strobe
  always @(negedge clk) begin
    if (!rst) begin
      if (data_stb) observe(K_DATA, int'(data_byte), 0);
      if (col_load) observe(K_COL, int'(col_start), int'(col_end));
      if (row_load) observe(K_ROW, int'(row_start), int'(row_end));
      if (cmd_err)  observe(K_ERR, 0, 0);
    end
  end

  task automatic send(input logic dc, input logic [7:0] b);
    byte_valid = 1'b1;
    dc_data    = dc;
    byte_in    = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(col_start == 0 && col_end == COL_W'(COLS - 1), "R1 col window", int'(col_end), COLS - 1);
    chk(row_start == 0 && row_end == ROW_W'(ROWS - 1), "R1 row window", int'(row_end), ROWS - 1);
    chk(remap == 8'h00, "R1 remap", int'(remap), 0);
    chk(contrast == 8'h7F, "R1 contrast", int'(contrast), 'h7F);
    chk(disp_on == 1'b0 && disp_mode == 2'd0, "R1 display", int'({disp_on, disp_mode}), 0);
    chk(!col_load && !row_load && !data_stb && !cmd_err, "R1 strobes", 1, 0);

    // R2 data pass-through, including an opcode-valued byte
    expect_ev(K_DATA, 'h15, 0, "R2");
    send(1'b1, 8'h15);
    expect_ev(K_DATA, 'h81, 0, "R2");
    send(1'b1, 8'h81);
    expect_ev(K_DATA, 'hAB, 0, "R2");
    send(1'b1, 8'hAB);
    chk(contrast == 8'h7F, "R2 contrast untouched", int'(contrast), 'h7F);

    // R3 column window
    send(1'b0, 8'h15); send(1'b0, 8'h05);
    expect_ev(K_COL, 5, 62, "R3");
    send(1'b0, 8'h3E);
    send(1'b0, 8'h15); send(1'b0, 8'h47);
    expect_ev(K_COL, 'h47 % COLS, 'hC0 % COLS, "R3 wrap");
    send(1'b0, 8'hC0);

    // R4 row window
    send(1'b0, 8'h75); send(1'b0, 8'h10);
    expect_ev(K_ROW, 16, 79, "R4");
    send(1'b0, 8'h4F);
    send(1'b0, 8'h75); send(1'b0, 8'h55);
    expect_ev(K_ROW, 'h55 % ROWS, 'hFF % ROWS, "R4 modulo");
    send(1'b0, 8'hFF);

    // R5 contrast, R6 remap
    send(1'b0, 8'h81); send(1'b0, 8'h33);
    chk(contrast == 8'h33, "R5 contrast", int'(contrast), 'h33);
    send(1'b0, 8'hA0); send(1'b0, 8'h52);
    chk(remap == 8'h52, "R6 remap", int'(remap), 'h52);

    // R7 modes and power
    send(1'b0, 8'hA5);
    chk(disp_mode == 2'd1, "R7 all on", int'(disp_mode), 1);
    send(1'b0, 8'hA6);
    chk(disp_mode == 2'd2, "R7 all off", int'(disp_mode), 2);
    send(1'b0, 8'hA7);
    chk(disp_mode == 2'd3, "R7 inverse", int'(disp_mode), 3);
    send(1'b0, 8'hA4);
    chk(disp_mode == 2'd0, "R7 normal", int'(disp_mode), 0);
    send(1'b0, 8'hAF);
    chk(disp_on == 1'b1, "R7 on", int'(disp_on), 1);
    send(1'b0, 8'hAE);
    chk(disp_on == 1'b0, "R7 off", int'(disp_on), 0);
    send(1'b0, 8'hAF);

    // R8 single-parameter ignored opcodes; parameters look like opcodes
    send(1'b0, 8'hB1); send(1'b0, 8'h81);
    send(1'b0, 8'h81); send(1'b0, 8'h22);
    chk(contrast == 8'h22, "R8 B1 skips one", int'(contrast), 'h22);
    send(1'b0, 8'hA8); send(1'b0, 8'h15);
    send(1'b0, 8'h15); send(1'b0, 8'h01);
    expect_ev(K_COL, 1, 2, "R8 A8 skips one");
    send(1'b0, 8'h02);
    send(1'b0, 8'hBF); send(1'b0, 8'hA7);
    chk(disp_mode == 2'd0, "R8 BF param not a mode", int'(disp_mode), 0);

    // R9 grey table consumes eight bytes
    send(1'b0, 8'hB8);
    for (int i = 0; i < 8; i++) send(1'b0, 8'h81);
    send(1'b0, 8'h81); send(1'b0, 8'h44);
    chk(contrast == 8'h44, "R9 grey table length", int'(contrast), 'h44);

    // R10 zero-parameter no-effect opcodes
    send(1'b0, 8'h84); send(1'b0, 8'h85); send(1'b0, 8'h86);
    send(1'b0, 8'hE3); send(1'b0, 8'hFF);
    send(1'b0, 8'h81); send(1'b0, 8'h55);
    chk(contrast == 8'h55, "R10 no-param opcodes", int'(contrast), 'h55);
    chk(disp_on == 1'b1 && remap == 8'h52, "R10 no side effect", int'(remap), 'h52);

    // R11 unknown opcodes
    expect_ev(K_ERR, 0, 0, "R11");
    send(1'b0, 8'h00);
    expect_ev(K_ERR, 0, 0, "R11");
    send(1'b0, 8'h42);
    send(1'b0, 8'h81); send(1'b0, 8'h66);
    chk(contrast == 8'h66, "R11 next byte is opcode", int'(contrast), 'h66);

    // R12 data mode abandons a partial command
    send(1'b0, 8'h15); send(1'b0, 8'h03);
    expect_ev(K_DATA, 'h99, 0, "R12 data");
    send(1'b1, 8'h99);
    send(1'b0, 8'h81); send(1'b0, 8'h11);
    chk(contrast == 8'h11, "R12 abandon", int'(contrast), 'h11);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R3/R4/R11 missing strobes", q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule